// File: doc/BRIEF.md
# UART FIFO Threshold Interrupt Generator

This block turns the fill levels of a UART's receive and transmit FIFOs into two active-low interrupt requests and a receive flow-control request. It is placed beside the FIFO storage. Each cycle it takes the current levels, the FIFO enable bit, the per-direction interrupt enables and the programmed threshold fields. All of its outputs are registered.

Each direction's threshold comes from one of two sources. A fine 4-bit trigger field, when nonzero, sets the threshold to four times its value. When that field is zero, a coarse 2-bit field picks one of four fixed levels. The receive request follows the receive level against its threshold. The transmit request has hysteresis: an empty transmit FIFO asserts it, and the level reaching the threshold releases it. A separate flow-control threshold drives a flow-control request, and a configuration flag reports when that threshold is programmed below the receive threshold.

Top module: `uart_fifo_irq_gen`

## Requirements
- R1: When `fifo_en` is 0, or the direction's enable (`rx_ie` or `tx_ie`) is 0 at a clock edge, that direction's request output is high after the edge.
- R2: If `rx_trig` is nonzero, the receive threshold is 4 × `rx_trig`.
- R3: If `rx_trig` is zero, `rx_sel` values 0, 1, 2 and 3 give receive thresholds of 8, 16, 56 and 60 entries.
- R4: If `tx_trig` is nonzero, the transmit threshold is 4 × `tx_trig`. Otherwise, `tx_sel` values 0, 1, 2 and 3 give 8, 16, 32 and 56.
- R5: When receive is enabled, `rx_irq_n` is 0 after an edge at which `rx_level` ≥ the receive threshold, and 1 after an edge at which it is below.
- R6: When transmit is enabled, `tx_irq_n` is 0 after an edge at which `tx_level` is 0.
- R7: When transmit is enabled, `tx_irq_n` is 1 after an edge at which `tx_level` ≥ the transmit threshold. At levels strictly between 0 and the threshold, it keeps its previous value.
- R8: `fc_req` is 1 after an edge at which `fifo_en` is 1 and `rx_level` ≥ the flow threshold, and 0 otherwise. The flow threshold is 4 × `fc_trig`, or 64 when `fc_trig` is zero.
- R9: `fc_cfg_err` is 1 after an edge at which the flow threshold is below the receive threshold, and 0 otherwise.
- R10: While `rst` is high, `rx_irq_n` and `tx_irq_n` are 1, and `fc_req` and `fc_cfg_err` are 0.
- R11: Disabling transmit clears the transmit hysteresis. After a re-enable, `tx_irq_n` stays 1 until `tx_level` has been 0 at an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable |
| rx_ie | input | 1 | Receive interrupt enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_sel | input | 2 | Coarse receive threshold select |
| tx_sel | input | 2 | Coarse transmit threshold select |
| rx_trig | input | 4 | Fine receive trigger (units of 4) |
| tx_trig | input | 4 | Fine transmit trigger (units of 4) |
| fc_trig | input | 4 | Flow-control trigger (units of 4, 0 = 64) |
| rx_level | input | 7 | Receive FIFO fill level, 0 to 64 |
| tx_level | input | 7 | Transmit FIFO fill level, 0 to 64 |
| rx_irq_n | output | 1 | Receive interrupt request, active low |
| tx_irq_n | output | 1 | Transmit interrupt request, active low |
| fc_req | output | 1 | Receive flow-control request |
| fc_cfg_err | output | 1 | Flow threshold below receive threshold |

## Verification
Every cycle, the assertions check the following:
- enable gating of both request outputs;
- the receive comparison against the selected threshold;
- transmit assertion on an empty FIFO, release at the threshold, and hold in between;
- the flow-control comparison and the configuration flag.

The threshold tables themselves, and the loss of transmit hysteresis across a disable, appear only in the bench's directed scenarios. In those scenarios, a behavioural model predicts every output for swept select values and levels just below, at and above each threshold.

// File: rtl/uart_fifo_irq_pkg.sv
package uart_fifo_irq_pkg;

    localparam int FIFO_DEPTH = 64;
    localparam int LEVEL_W    = $clog2(FIFO_DEPTH + 1);
    localparam int TRIG_W     = 4;
    localparam int SEL_W      = 2;

    typedef logic [LEVEL_W-1:0] level_t;
    typedef logic [TRIG_W-1:0]  trig_t;
    typedef logic [SEL_W-1:0]   sel_t;

    typedef enum logic {THR_RX = 1'b0, THR_TX = 1'b1} thr_dir_e;

    typedef struct packed {
        logic rx_n;
        logic tx_n;
        logic fc;
        logic cfg_err;
    } irq_out_t;

    // fine trigger: four entries per step
    function automatic level_t trig_level(trig_t n);
        return level_t'({n, 2'b00});
    endfunction

    function automatic level_t rx_fixed(sel_t s);
        case (s)
            2'd0:    return level_t'(8);
            2'd1:    return level_t'(16);
            2'd2:    return level_t'(56);
            default: return level_t'(60);
        endcase
    endfunction

    function automatic level_t tx_fixed(sel_t s);
        case (s)
            2'd0:    return level_t'(8);
            2'd1:    return level_t'(16);
            2'd2:    return level_t'(32);
            default: return level_t'(56);
        endcase
    endfunction

    // flow threshold: zero code means a full FIFO
    function automatic level_t fc_level(trig_t n);
        return (n == '0) ? level_t'(FIFO_DEPTH) : trig_level(n);
    endfunction

endpackage

// File: rtl/uart_thr_select.sv
module uart_thr_select
    import uart_fifo_irq_pkg::*;
#(
    parameter thr_dir_e DIR = THR_RX
) (
    input  trig_t  trig,
    input  sel_t   sel,
    output level_t thr
);
    level_t fixed_thr;

    generate
        if (DIR == THR_RX) begin : g_rx_table
            assign fixed_thr = rx_fixed(sel);
        end else begin : g_tx_table
            assign fixed_thr = tx_fixed(sel);
        end
    endgenerate

    assign thr = (trig != '0) ? trig_level(trig) : fixed_thr;
endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
    import uart_fifo_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  level_t level,
    input  level_t thr,
    output logic   irq_n
);
    always_ff @(posedge clk) begin
        if (rst)
            irq_n <= 1'b1;
        else
            irq_n <= !(enable && (level >= thr));
    end
endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq
    import uart_fifo_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  level_t level,
    input  level_t thr,
    output logic   irq_n
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (!enable)
            armed <= 1'b0;
        else if (level == '0)
            armed <= 1'b1;
        else if (level >= thr)
            armed <= 1'b0;
    end

    assign irq_n = ~armed;
endmodule

// File: rtl/uart_fc_ctl.sv
module uart_fc_ctl
    import uart_fifo_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fifo_en,
    input  level_t rx_level,
    input  trig_t  fc_trig,
    input  level_t rx_thr,
    output level_t fc_thr,
    output logic   fc_req,
    output logic   cfg_err
);
    assign fc_thr = fc_level(fc_trig);

    always_ff @(posedge clk) begin
        if (rst) begin
            fc_req  <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            fc_req  <= fifo_en && (rx_level >= fc_thr);
            cfg_err <= (fc_thr < rx_thr);
        end
    end
endmodule

// File: rtl/uart_fifo_irq_gen.sv
module uart_fifo_irq_gen
    import uart_fifo_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_en,
    input  logic       rx_ie,
    input  logic       tx_ie,
    input  logic [1:0] rx_sel,
    input  logic [1:0] tx_sel,
    input  logic [3:0] rx_trig,
    input  logic [3:0] tx_trig,
    input  logic [3:0] fc_trig,
    input  logic [6:0] rx_level,
    input  logic [6:0] tx_level,
    output logic       rx_irq_n,
    output logic       tx_irq_n,
    output logic       fc_req,
    output logic       fc_cfg_err
);
    level_t   rx_thr;
    level_t   tx_thr;
    level_t   fc_thr;
    irq_out_t outs;

    uart_thr_select #(.DIR(THR_RX)) u_rx_sel (
        .trig (rx_trig),
        .sel  (rx_sel),
        .thr  (rx_thr)
    );

    uart_thr_select #(.DIR(THR_TX)) u_tx_sel (
        .trig (tx_trig),
        .sel  (tx_sel),
        .thr  (tx_thr)
    );

    uart_rx_irq u_rx_irq (
        .clk    (clk),
        .rst    (rst),
        .enable (fifo_en && rx_ie),
        .level  (rx_level),
        .thr    (rx_thr),
        .irq_n  (outs.rx_n)
    );

    uart_tx_irq u_tx_irq (
        .clk    (clk),
        .rst    (rst),
        .enable (fifo_en && tx_ie),
        .level  (tx_level),
        .thr    (tx_thr),
        .irq_n  (outs.tx_n)
    );

    uart_fc_ctl u_fc (
        .clk      (clk),
        .rst      (rst),
        .fifo_en  (fifo_en),
        .rx_level (rx_level),
        .fc_trig  (fc_trig),
        .rx_thr   (rx_thr),
        .fc_thr   (fc_thr),
        .fc_req   (outs.fc),
        .cfg_err  (outs.cfg_err)
    );

    assign rx_irq_n   = outs.rx_n;
    assign tx_irq_n   = outs.tx_n;
    assign fc_req     = outs.fc;
    assign fc_cfg_err = outs.cfg_err;
endmodule

// File: rtl/uart_fifo_irq_gen_chk.sv
module uart_fifo_irq_gen_chk
    import uart_fifo_irq_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   fifo_en,
    input logic   rx_ie,
    input logic   tx_ie,
    input level_t rx_level,
    input level_t tx_level,
    input level_t rx_thr,
    input level_t tx_thr,
    input level_t fc_thr,
    input logic   rx_irq_n,
    input logic   tx_irq_n,
    input logic   fc_req,
    input logic   fc_cfg_err
);
    assert_rx_gate_R1: assert property (@(posedge clk) disable iff (rst)
        !(fifo_en && rx_ie) |=> rx_irq_n);

    assert_tx_gate_R1: assert property (@(posedge clk) disable iff (rst)
        !(fifo_en && tx_ie) |=> tx_irq_n);

    assert_rx_level_R5: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && rx_ie && rx_level >= rx_thr) |=> !rx_irq_n);

    assert_rx_below_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_level < rx_thr) |=> rx_irq_n);

    assert_tx_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && tx_ie && tx_level == '0) |=> !tx_irq_n);

    assert_tx_release_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_level != '0 && tx_level >= tx_thr) |=> tx_irq_n);

    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && tx_ie && tx_level != '0 && tx_level < tx_thr)
        |=> (tx_irq_n == $past(tx_irq_n)));

    assert_fc_req_R8: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && rx_level >= fc_thr) |=> fc_req);

    assert_fc_off_R8: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en || rx_level < fc_thr) |=> !fc_req);

    assert_cfg_err_R9: assert property (@(posedge clk) disable iff (rst)
        (fc_thr < rx_thr) |=> fc_cfg_err);
endmodule

bind uart_fifo_irq_gen uart_fifo_irq_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .rx_ie      (rx_ie),
    .tx_ie      (tx_ie),
    .rx_level   (rx_level),
    .tx_level   (tx_level),
    .rx_thr     (rx_thr),
    .tx_thr     (tx_thr),
    .fc_thr     (fc_thr),
    .rx_irq_n   (rx_irq_n),
    .tx_irq_n   (tx_irq_n),
    .fc_req     (fc_req),
    .fc_cfg_err (fc_cfg_err)
);

// File: tb/uart_fifo_irq_gen_test.sv
module uart_fifo_irq_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b0, rx_ie = 1'b0, tx_ie = 1'b0;
    logic [1:0] rx_sel = '0, tx_sel = '0;
    logic [3:0] rx_trig = '0, tx_trig = '0, fc_trig = '0;
    logic [6:0] rx_level = '0, tx_level = '0;
    logic       rx_irq_n, tx_irq_n, fc_req, fc_cfg_err;

    int    checks = 0;
    int    errors = 0;
    string tag = "R10";

    // model state
    bit m_armed = 0;
    bit e_rx_n = 1, e_tx_n = 1, e_fc = 0, e_err = 0;

    always #2 clk = ~clk;

    uart_fifo_irq_gen uut (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_ie(rx_ie), .tx_ie(tx_ie),
        .rx_sel(rx_sel), .tx_sel(tx_sel), .rx_trig(rx_trig), .tx_trig(tx_trig),
        .fc_trig(fc_trig), .rx_level(rx_level), .tx_level(tx_level),
        .rx_irq_n(rx_irq_n), .tx_irq_n(tx_irq_n), .fc_req(fc_req),
        .fc_cfg_err(fc_cfg_err)
    );

    function automatic int m_rx_thr();
        int t[4] = '{8, 16, 56, 60};
        return (rx_trig != 0) ? 4 * int'(rx_trig) : t[rx_sel];
    endfunction

    function automatic int m_tx_thr();
        int t[4] = '{8, 16, 32, 56};
        return (tx_trig != 0) ? 4 * int'(tx_trig) : t[tx_sel];
    endfunction

    function automatic int m_fc_thr();
        return (fc_trig == 0) ? 64 : 4 * int'(fc_trig);
    endfunction

    task automatic check(string name, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, name, act, exp);
        end
    endtask

    task automatic compare_all();
        check("rx_irq_n", rx_irq_n, e_rx_n);
        check("tx_irq_n", tx_irq_n, e_tx_n);
        check("fc_req", fc_req, e_fc);
        check("fc_cfg_err", fc_cfg_err, e_err);
    endtask

    // one clock: model updates with the inputs seen at the edge
    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_armed = 0; e_rx_n = 1; e_fc = 0; e_err = 0;
        end else begin
            e_rx_n = !(fifo_en && rx_ie && int'(rx_level) >= m_rx_thr());
            if (!(fifo_en && tx_ie)) m_armed = 0;
            else if (tx_level == 0) m_armed = 1;
            else if (int'(tx_level) >= m_tx_thr()) m_armed = 0;
            e_fc  = fifo_en && int'(rx_level) >= m_fc_thr();
            e_err = m_fc_thr() < m_rx_thr();
        end
        e_tx_n = !m_armed;
        @(negedge clk);
        compare_all();
    endtask

    task automatic rx_at(int lvl); rx_level = 7'(lvl); tick(); endtask
    task automatic tx_at(int lvl); tx_level = 7'(lvl); tick(); endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10: reset state
        tag = "R10";
        fifo_en = 1; rx_ie = 1; tx_ie = 1; rx_level = 64;
        tick(); tick();
        rx_level = 0; tx_level = 5;
        rst = 0;
        @(negedge clk);

        // R3: coarse receive table with R5 comparisons
        tag = "R3_R5";
        for (int s = 0; s < 4; s++) begin
            rx_sel = 2'(s);
            rx_at(m_rx_thr() - 1);
            rx_at(m_rx_thr());
            rx_at(m_rx_thr() + 1 > 64 ? 64 : m_rx_thr() + 1);
            rx_at(m_rx_thr() - 1);
        end

        // R2: fine receive trigger
        tag = "R2";
        for (int n = 1; n < 16; n += 4) begin
            rx_trig = 4'(n);
            rx_at(4 * n - 1);
            rx_at(4 * n);
            rx_at(0);
        end
        rx_trig = 0; rx_sel = 0;

        // R4, R6, R7: transmit tables and hysteresis
        tag = "R4_R6_R7";
        for (int s = 0; s < 4; s++) begin
            tx_sel = 2'(s);
            tx_at(0);
            tx_at(m_tx_thr() - 1);
            tx_at(m_tx_thr());
            tx_at(m_tx_thr() - 1);
            tx_at(1);
            tx_at(0);
            tx_at(3);
        end
        tx_trig = 3;
        tx_at(0); tx_at(11); tx_at(12); tx_at(5); tx_at(0);
        tx_trig = 0; tx_sel = 0;

        // R8: flow-control threshold, zero code = 64
        tag = "R8";
        fc_trig = 0;
        rx_at(63); rx_at(64); rx_at(20);
        fc_trig = 10;
        rx_at(39); rx_at(40); rx_at(41); rx_at(39);

        // R9: flow threshold below receive threshold
        tag = "R9";
        rx_trig = 5; fc_trig = 2;
        rx_at(10);
        fc_trig = 5;
        rx_at(10);
        fc_trig = 4;
        rx_at(10);
        rx_trig = 0; fc_trig = 15;

        // R1: enable gating
        tag = "R1";
        rx_at(60); tx_at(0);
        rx_ie = 0; tick();
        rx_ie = 1; tick();
        fifo_en = 0; tick(); tick();
        fifo_en = 1; tick();
        tx_ie = 0; tick();

        // R11: hysteresis lost across a disable
        tag = "R11";
        tx_ie = 1; tx_at(0); tx_at(4);
        tx_ie = 0; tick();
        tx_ie = 1; tx_at(5); tx_at(6); tx_at(0); tx_at(4);

        // mixed sweep
        tag = "R5_R7_R8";
        for (int i = 0; i < 400; i++) begin
            rx_level = 7'((i * 37) % 65);
            tx_level = 7'((i * 23) % 17 == 0 ? 0 : (i * 29) % 65);
            if (i % 50 == 0) begin
                rx_sel = 2'(i / 50); tx_sel = 2'(i / 50 + 1);
                rx_trig = 4'(i % 3 == 0 ? 0 : i / 30);
                fc_trig = 4'(i / 27);
            end
            if (i % 97 == 5) fifo_en = ~fifo_en;
            tick();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule